// File: doc/BRIEF.md
# Vector-Window RAM Overlay Remapper

This block sits on a CPU address bus in front of two on-chip targets: a flash array occupying the bottom half of the address space and a RAM region at the top. Ordinarily it only decides which target an access reaches and passes the address through unchanged. When software has armed it, and the external programming-voltage indicator shows that flash is being programmed or erased, it redirects any access to the lowest 128 bytes of flash into a fixed 128-byte RAM window. The exception vectors, including the non-maskable interrupt vector at 0x0006, can then be fetched from RAM while the flash array is unreadable.

Software arms the overlay through an 8-bit control register that holds two arm bits. The voltage indicator is asynchronous and passes through a two-flop synchronizer before it can gate the overlay. The target decode itself is combinational, so every access is translated in the cycle in which it is presented. When a boot-mode input is high at reset, both arm bits start set. They stay set until software clears them.

Top module: `ovl_remap_top`

## Requirements
- R1: Under synchronous reset the control register reads 0x00 when boot_mode is low and 0x0C when boot_mode is high. 0x0C means arm bits 3 and 2 are set.
- R2: A write with cfg_we high stores all 8 bits of cfg_wdata at the clock edge, and cfg_rdata shows them after that edge. Without a write the register keeps its value.
- R3: With acc_req low, neither flash_sel nor ram_sel is asserted, and mem_addr equals acc_addr.
- R4: A requested access to 0x0080–0x7FFF always asserts flash_sel only, with mem_addr equal to acc_addr.
- R5: A requested access at or above 0xFC00 always asserts ram_sel only, with mem_addr equal to acc_addr.
- R6: A requested access to 0x8000–0xFBFF asserts neither select, and mem_addr equals acc_addr.
- R7: The overlay is active when control bits 3 and 2 are both 1 and the synchronized voltage flag is high. While it is active, a requested access to 0x0000–0x007F asserts ram_sel only and gives mem_addr = 0xFC00 | acc_addr[6:0]. For example, 0x0006 maps to 0xFC06.
- R8: While the overlay is not active (either arm bit is 0, or the synchronized flag is low), a requested access to 0x0000–0x007F asserts flash_sel only, with mem_addr equal to acc_addr.
- R9: A change on vpp_async first affects the decode after the second rising clock edge following the change. After one edge the old behaviour still holds.
- R10: Arm bits preset by a boot-mode reset keep the overlay armed over idle cycles until software writes them to 0. After that write, the vector window reaches flash even with the voltage flag high.
- R11: The decode is combinational. The selects and mem_addr for an access are valid in the same cycle as acc_addr and acc_req, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_mode | input | 1 | When high at reset, presets both arm bits |
| vpp_async | input | 1 | Asynchronous programming-voltage-present indicator |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register contents |
| acc_req | input | 1 | CPU access request |
| acc_addr | input | 16 | CPU byte address |
| flash_sel | output | 1 | Access goes to flash |
| ram_sel | output | 1 | Access goes to RAM |
| mem_addr | output | 16 | Translated address for the selected target |

## Verification
The hardest case to reach is the exact edge at which the overlay switches after the voltage input moves, because only the vector window's select shows it. The stimulus changes vpp_async on a falling edge and presents address 0x0006 at once. It presents the same address again one edge and two edges later, and expects the old target twice and the new target once. This is done for both a rising and a falling indicator. The boot-mode reset is the second case that is hard to reach. The bench applies it, leaves several idle cycles and then clears the arm bits. The vector fetch has to follow that clearing even though the voltage stays high.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_FLASH = 2'd1,
    TGT_RAM   = 2'd2
  } tgt_e;

endpackage

// File: rtl/ovl_ctrl_reg.sv
module ovl_ctrl_reg #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned HI_BIT = 3,
  parameter int unsigned LO_BIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_mode,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              armed
);

  localparam logic [DATA_W-1:0] BOOT_VAL = DATA_W'((1 << HI_BIT) | (1 << LO_BIT));

  logic [DATA_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= boot_mode ? BOOT_VAL : '0;
    end else if (we) begin
      ctrl_q <= wdata;
    end
  end

  assign rdata = ctrl_q;
  assign armed = ctrl_q[HI_BIT] & ctrl_q[LO_BIT];

  // R1
  boot_preset_chk: assert property (@(posedge clk)
    (rst && boot_mode) |=> (rdata == BOOT_VAL));

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(rdata));

endmodule

// File: rtl/ovl_vsync.sv
module ovl_vsync (
  input  logic clk,
  input  logic rst,
  input  logic vpp_async,
  output logic vpp_ok
);

  logic meta_q;
  logic stable_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q   <= 1'b0;
      stable_q <= 1'b0;
    end else begin
      meta_q   <= vpp_async;
      stable_q <= meta_q;
    end
  end

  assign vpp_ok = stable_q;

  // Age counter so that the latency check only looks back over cycles after reset.
  logic [1:0] age_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      age_q <= 2'd0;
    end else if (age_q != 2'd2) begin
      age_q <= age_q + 2'd1;
    end
  end

  // R9
  vpp_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (age_q == 2'd2) |-> (vpp_ok == $past(vpp_async, 2)));

endmodule

// File: rtl/ovl_decode.sv
module ovl_decode
  import ovl_pkg::*;
#(
  parameter int unsigned           ADDR_W    = 16,
  parameter int unsigned           WIN_BITS  = 7,
  parameter logic [ADDR_W-1:0]     FLASH_TOP = 'h7FFF,
  parameter logic [ADDR_W-1:0]     RAM_BASE  = 'hFC00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              overlay,
  output logic              flash_sel,
  output logic              ram_sel,
  output logic [ADDR_W-1:0] xaddr
);

  localparam int unsigned HI_W = ADDR_W - WIN_BITS;

  logic              in_win;
  logic              in_flash;
  logic              in_ram;
  logic [ADDR_W-1:0] win_addr;
  tgt_e              tgt;

  assign in_win   = (addr[ADDR_W-1:WIN_BITS] == {HI_W{1'b0}});
  assign in_flash = (addr <= FLASH_TOP);
  assign in_ram   = (addr >= RAM_BASE);
  assign win_addr = {RAM_BASE[ADDR_W-1:WIN_BITS], addr[WIN_BITS-1:0]};

  always_comb begin
    tgt   = TGT_NONE;
    xaddr = addr;
    if (req) begin
      if (in_win && overlay) begin
        tgt   = TGT_RAM;
        xaddr = win_addr;
      end else if (in_flash) begin
        tgt = TGT_FLASH;
      end else if (in_ram) begin
        tgt = TGT_RAM;
      end
    end
  end

  assign flash_sel = (tgt == TGT_FLASH);
  assign ram_sel   = (tgt == TGT_RAM);

  // R4 R5 R7 R8: at most one target at a time
  mutex_sel_chk: assert property (@(posedge clk) disable iff (rst)
    !(flash_sel && ram_sel));

  // R3
  idle_no_sel_chk: assert property (@(posedge clk) disable iff (rst)
    !req |-> (!flash_sel && !ram_sel && xaddr == addr));

endmodule

// File: rtl/ovl_remap_top.sv
module ovl_remap_top #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned WIN_BITS  = 7,
  parameter int unsigned ARM_HI    = 3,
  parameter int unsigned ARM_LO    = 2,
  parameter logic [ADDR_W-1:0] FLASH_TOP = 'h7FFF,
  parameter logic [ADDR_W-1:0] RAM_BASE  = 'hFC00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_mode,
  input  logic              vpp_async,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              acc_req,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              flash_sel,
  output logic              ram_sel,
  output logic [ADDR_W-1:0] mem_addr
);

  logic armed;
  logic vpp_ok;
  logic ovl_active;

  ovl_ctrl_reg #(
    .DATA_W (DATA_W),
    .HI_BIT (ARM_HI),
    .LO_BIT (ARM_LO)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .boot_mode (boot_mode),
    .we        (cfg_we),
    .wdata     (cfg_wdata),
    .rdata     (cfg_rdata),
    .armed     (armed)
  );

  ovl_vsync u_vsync (
    .clk       (clk),
    .rst       (rst),
    .vpp_async (vpp_async),
    .vpp_ok    (vpp_ok)
  );

  assign ovl_active = armed & vpp_ok;

  ovl_decode #(
    .ADDR_W    (ADDR_W),
    .WIN_BITS  (WIN_BITS),
    .FLASH_TOP (FLASH_TOP),
    .RAM_BASE  (RAM_BASE)
  ) u_dec (
    .clk       (clk),
    .rst       (rst),
    .req       (acc_req),
    .addr      (acc_addr),
    .overlay   (ovl_active),
    .flash_sel (flash_sel),
    .ram_sel   (ram_sel),
    .xaddr     (mem_addr)
  );

  // R5
  ram_direct_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_req && acc_addr >= RAM_BASE) |-> (ram_sel && !flash_sel && mem_addr == acc_addr));

  // R7
  win_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_req && ovl_active && acc_addr[ADDR_W-1:WIN_BITS] == '0)
      |-> (ram_sel && mem_addr[WIN_BITS-1:0] == acc_addr[WIN_BITS-1:0]
           && mem_addr >= RAM_BASE));

  // R8
  win_flash_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_req && !ovl_active && acc_addr <= FLASH_TOP) |-> (flash_sel && mem_addr == acc_addr));

endmodule

// File: tb/ovl_remap_top_bench.sv
`timescale 1ns/1ps
module ovl_remap_top_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        boot_mode = 1'b0;
  logic        vpp_async = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic        acc_req = 1'b0;
  logic [15:0] acc_addr = 16'h0000;
  logic        flash_sel;
  logic        ram_sel;
  logic [15:0] mem_addr;

  always #2.5 clk = ~clk;

  ovl_remap_top u_ovl_remap_top (
    .clk       (clk),
    .rst       (rst),
    .boot_mode (boot_mode),
    .vpp_async (vpp_async),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .acc_req   (acc_req),
    .acc_addr  (acc_addr),
    .flash_sel (flash_sel),
    .ram_sel   (ram_sel),
    .mem_addr  (mem_addr)
  );

  typedef struct {
    logic        f;
    logic        r;
    logic [15:0] a;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  event mon_ev;

  // Monitor: pops one expected item per sampled access
  initial begin
    forever begin
      @(mon_ev);
      if (exp_q.size() != 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_cmp++;
        if (flash_sel !== e.f || ram_sel !== e.r || mem_addr !== e.a) begin
          n_bad++;
          $display("FAIL %s: got f=%0b r=%0b a=%h, expected f=%0b r=%0b a=%h",
                   e.tag, flash_sel, ram_sel, mem_addr, e.f, e.r, e.a);
        end
      end
    end
  end

  // Driver: call right after a falling edge; drives, queues expectation, samples before next rise (R11)
  task automatic apply(input logic req, input logic [15:0] a,
                       input logic ef, input logic er, input logic [15:0] ea,
                       input string tag);
    exp_t e;
    acc_req  = req;
    acc_addr = a;
    e.f = ef; e.r = er; e.a = ea; e.tag = tag;
    exp_q.push_back(e);
    #1;
    ->mon_ev;
    #0;
  endtask

  task automatic check_reg(input logic [7:0] exp, input string tag);
    #1;
    n_cmp++;
    if (cfg_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: cfg_rdata got %h, expected %h", tag, cfg_rdata, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #20000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1 normal reset
    wait_neg(3);
    rst = 1'b0;
    check_reg(8'h00, "R1 reset value");

    // voltage high, not armed -> R8
    vpp_async = 1'b1;
    wait_neg(3);
    apply(1'b1, 16'h0006, 1'b1, 1'b0, 16'h0006, "R8 unarmed window");

    // only bit 3 set -> still flash (R8), R2 readback
    cfg_write(8'h08);
    check_reg(8'h08, "R2 write 08");
    apply(1'b1, 16'h0006, 1'b1, 1'b0, 16'h0006, "R8 one arm bit");

    // fully armed
    cfg_write(8'h0C);
    apply(1'b1, 16'h0006, 1'b0, 1'b1, 16'hFC06, "R7 vector");
    wait_neg(1); apply(1'b1, 16'h007F, 1'b0, 1'b1, 16'hFC7F, "R7 window top");
    wait_neg(1); apply(1'b1, 16'h0000, 1'b0, 1'b1, 16'hFC00, "R7 window base");
    wait_neg(1); apply(1'b1, 16'h0080, 1'b1, 1'b0, 16'h0080, "R4 above window");
    wait_neg(1); apply(1'b1, 16'h7FFF, 1'b1, 1'b0, 16'h7FFF, "R4 flash top");
    wait_neg(1); apply(1'b1, 16'hFC10, 1'b0, 1'b1, 16'hFC10, "R5 ram direct");
    wait_neg(1); apply(1'b1, 16'hFFFF, 1'b0, 1'b1, 16'hFFFF, "R5 ram top");
    wait_neg(1); apply(1'b1, 16'h8000, 1'b0, 1'b0, 16'h8000, "R6 gap low");
    wait_neg(1); apply(1'b1, 16'hFBFF, 1'b0, 1'b0, 16'hFBFF, "R6 gap high");
    wait_neg(1); apply(1'b0, 16'h0006, 1'b0, 1'b0, 16'h0006, "R3 idle window");
    wait_neg(1); apply(1'b0, 16'hFC00, 1'b0, 1'b0, 16'hFC00, "R3 idle ram");

    // R9 falling voltage: old, old, new
    wait_neg(1);
    vpp_async = 1'b0;
    apply(1'b1, 16'h0006, 1'b0, 1'b1, 16'hFC06, "R9 fall edge0");
    wait_neg(1); apply(1'b1, 16'h0006, 1'b0, 1'b1, 16'hFC06, "R9 fall edge1");
    wait_neg(1); apply(1'b1, 16'h0006, 1'b1, 1'b0, 16'h0006, "R9 fall edge2");
    // R9 rising voltage
    wait_neg(1);
    vpp_async = 1'b1;
    apply(1'b1, 16'h0006, 1'b1, 1'b0, 16'h0006, "R9 rise edge0");
    wait_neg(1); apply(1'b1, 16'h0006, 1'b1, 1'b0, 16'h0006, "R9 rise edge1");
    wait_neg(1); apply(1'b1, 16'h0006, 1'b0, 1'b1, 16'hFC06, "R9 rise edge2");

    // R2 other bits writable, arm bits cleared -> R8
    cfg_write(8'hF3);
    check_reg(8'hF3, "R2 write F3");
    apply(1'b1, 16'h0006, 1'b1, 1'b0, 16'h0006, "R8 disarmed vpp high");
    wait_neg(4);
    check_reg(8'hF3, "R2 hold");

    // boot-mode reset
    @(negedge clk);
    rst = 1'b1; boot_mode = 1'b1;
    wait_neg(2);
    rst = 1'b0;
    check_reg(8'h0C, "R1 boot reset value");
    wait_neg(6);
    check_reg(8'h0C, "R10 boot bits held");
    apply(1'b1, 16'h0006, 1'b0, 1'b1, 16'hFC06, "R10 boot overlay");
    cfg_write(8'h00);
    check_reg(8'h00, "R10 cleared");
    apply(1'b1, 16'h0006, 1'b1, 1'b0, 16'h0006, "R10 cleared window flash");

    wait_neg(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule